// File: doc/BRIEF.md
# Repeating Word-to-Serial Record Sender

This block turns a 16-bit word into a continuous stream of text-style records on an asynchronous serial transmit line. Each record holds four characters: the upper byte of the word, the lower byte, a carriage return and a line feed. Once the last character of a record has left the line, a one-cycle end-of-record strobe fires. The sequencer then re-arms on its own, and the next record follows with no action from outside.

Inside, a record sequencer chooses the byte for each slot and passes it to a serial transmitter core over a valid/ready hand-off. The sequencer raises valid and holds it, together with the byte, until the core shows ready, and the byte is taken on the cycle where both are high. The core drops ready from that cycle until its stop bit has been fully sent, which is how it applies back-pressure to the sequencer. The bit time is set by a clocks-per-bit parameter. At a 10 MHz clock, 87 clocks per bit gives roughly 115200 baud.

Top module: `word_uart_streamer`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the transmit line is driven high (idle) and the done strobe is low from the next clock edge onward.
- R2: Every character is ten bit slots of exactly CLKS_PER_BIT clock cycles each: a low start slot, eight data slots least significant bit first, and a high stop slot.
- R3: A record is sent in this order: word bits 15:8, word bits 7:0, 0x0D, then 0x0A.
- R4: The done strobe is high for exactly one cycle per record, in the second cycle after the line-feed stop slot ends, and it is never high at any other time.
- R5: After the done strobe the next record starts by itself with the upper byte, so records repeat with no limit.
- R6: The start slot of a character does not begin before the stop slot of the previous character is complete. The sequencer keeps a byte offered until the core accepts it.
- R7: Between two characters of the same record the line stays high for exactly 2 extra cycles after the stop slot. Between the line feed and the next record it stays high for exactly 3.
- R8: Each data byte is taken from the word at the moment it is handed to the transmitter. If the word changes while the line feed is being sent, the next record carries the new word in both data bytes.
- R9: A reset in the middle of a record drops the character being sent. The start slot of the upper byte begins on the first clock edge at which reset is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | 16 | Word sent in each record |
| tx_o | output | 1 | Serial transmit line, idles high |
| done_o | output | 1 | One-cycle end-of-record strobe |

## Verification
The hardest conditions to reach from the ports are a word change that must not affect the record in flight, and a reset that cuts off a character halfway through. The bench reads the line continuously, one sample per clock cycle, and rebuilds each frame bit slot by bit slot. This lets it change the word exactly when the line-feed frame begins. It also lets it pull reset a few cycles into a data character and then confirm that the next start edge comes on the first edge after reset is released, carrying the upper byte. The gap lengths and the cycle the done strobe lands on are counted in the same sample stream, so an off-by-one in the hand-off shows up directly.

// File: rtl/wus_pkg.sv
package wus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ASCII_CR = 8'h0D;
  localparam logic [BYTE_W-1:0] ASCII_LF = 8'h0A;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [1:0] {SQ_LOAD, SQ_WAIT, SQ_END} seq_state_e;
endpackage

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import wus_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 87,
  parameter int unsigned DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  output logic                 tx,
  output logic                 char_done
);
  localparam int unsigned CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  tx_state_e            st;
  logic [CW-1:0]        tick;
  logic [IW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 slot_end;

  assign slot_end = (tick == CW'(CLKS_PER_BIT - 1));
  assign in_ready = (st == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_IDLE;
      tick      <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      char_done <= 1'b0;
    end else begin
      char_done <= 1'b0;
      case (st)
        TX_IDLE: begin
          tick <= '0;
          if (in_valid) begin
            shreg <= in_data;
            st    <= TX_START;
          end
        end
        TX_START: begin
          if (slot_end) begin
            tick    <= '0;
            bit_idx <= '0;
            st      <= TX_DATA;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        TX_DATA: begin
          if (slot_end) begin
            tick <= '0;
            if (bit_idx == IW'(DATA_BITS - 1)) st <= TX_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          if (slot_end) begin
            tick      <= '0;
            st        <= TX_IDLE;
            char_done <= 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st)
      TX_START: tx = 1'b0;
      TX_DATA:  tx = shreg[bit_idx];
      default:  tx = 1'b1;
    endcase
  end

  // R1: line idle and no completion while reset is applied
  p_idle_in_reset_r1: assert property (@(posedge clk) rst |=> (tx && !char_done));
  // R2: an accepted byte pulls the line low on the next cycle
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !tx);
  // R2: completion is a single-cycle pulse
  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    char_done |=> !char_done);
  // R6: completion only after a high stop slot, and the core is free again
  p_stop_before_done_r6: assert property (@(posedge clk) disable iff (rst)
    char_done |-> ($past(tx) && in_ready));
endmodule

// File: rtl/record_sequencer.sv
module record_sequencer
  import wus_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              char_done,
  output logic              rec_done
);
  localparam int unsigned BPW   = WORD_W / BYTE_W;
  localparam int unsigned SLOTS = BPW + 2;
  localparam int unsigned SW    = $clog2(SLOTS);

  seq_state_e      st;
  logic [SW-1:0]   slot;
  logic [BYTE_W-1:0] word_bytes [BPW];

  for (genvar g = 0; g < BPW; g++) begin : g_split
    assign word_bytes[g] = word[WORD_W-1-BYTE_W*g -: BYTE_W];
  end

  always_comb begin
    out_data = (slot == SW'(BPW)) ? ASCII_CR : ASCII_LF;
    for (int i = 0; i < BPW; i++) begin
      if (slot == SW'(i)) out_data = word_bytes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_LOAD;
      slot <= '0;
    end else begin
      case (st)
        SQ_LOAD: if (out_ready) st <= SQ_WAIT;
        SQ_WAIT: begin
          if (char_done) begin
            if (slot == SW'(SLOTS - 1)) begin
              st <= SQ_END;
            end else begin
              slot <= slot + 1'b1;
              st   <= SQ_LOAD;
            end
          end
        end
        default: begin
          slot <= '0;
          st   <= SQ_LOAD;
        end
      endcase
    end
  end

  assign out_valid = (st == SQ_LOAD);
  assign rec_done  = (st == SQ_END);

  // R4: end-of-record strobe lasts one cycle and follows a finished character
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !rec_done);
  p_done_after_char_r4: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> $past(char_done));
  // R5: the strobe re-arms the sequence
  p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> out_valid);
  // R9: after reset the first byte is offered at once
  p_offer_after_reset_r9: assert property (@(posedge clk) rst |=> out_valid);
  // R6: an offered byte stays offered until taken
  p_hold_offer_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/word_uart_streamer.sv
module word_uart_streamer
  import wus_pkg::*;
#(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned CLKS_PER_BIT = 87
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  output logic              tx_o,
  output logic              done_o
);
  logic              hs_valid;
  logic              hs_ready;
  logic [BYTE_W-1:0] hs_data;
  logic              char_done;

  record_sequencer #(.WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .word      (word_i),
    .out_valid (hs_valid),
    .out_data  (hs_data),
    .out_ready (hs_ready),
    .char_done (char_done),
    .rec_done  (done_o)
  );

  uart_tx_core #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(BYTE_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (hs_valid),
    .in_data   (hs_data),
    .in_ready  (hs_ready),
    .tx        (tx_o),
    .char_done (char_done)
  );

  // R4: the strobe falls in an idle gap, never inside a frame
  p_done_in_gap_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> tx_o);
endmodule

// File: tb/tb_word_uart_streamer.sv
module tb_word_uart_streamer;
  localparam int C = 8;
  localparam int FR = 10 * C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] word = 16'hAB7C;
  logic        tx, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  word_uart_streamer #(.WORD_W(16), .CLKS_PER_BIT(C)) dut (
    .clk(clk), .rst(rst), .word_i(word), .tx_o(tx), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_start(output int cyc);
    cyc = 0;
    @(negedge clk);
    while (tx !== 1'b0 && cyc < 4 * FR) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Entered on the first negedge where the line is low; leaves on the next one.
  task automatic get_char(output logic [7:0] b, output bit frame_ok,
                          output int gap, output int done_at, output int done_n);
    logic s [FR];
    frame_ok = 1'b1;
    done_n = 0;
    done_at = -1;
    for (int i = 0; i < FR; i++) begin
      if (i > 0) @(negedge clk);
      s[i] = tx;
      if (done) done_n++;
    end
    for (int k = 0; k < 10; k++)
      for (int j = 1; j < C; j++)
        if (s[k*C+j] !== s[k*C]) frame_ok = 1'b0;
    if (s[0] !== 1'b0 || s[9*C] !== 1'b1) frame_ok = 1'b0;
    for (int k = 0; k < 8; k++) b[k] = s[(k+1)*C];
    gap = 0;
    @(negedge clk);
    while (tx === 1'b1 && gap < 64) begin
      if (done) begin done_n++; done_at = gap; end
      gap++;
      @(negedge clk);
    end
  endtask

  task automatic t_record(input logic [15:0] w, input logic [15:0] w_next, input string tag);
    logic [7:0] exp_b [4];
    logic [7:0] b;
    bit fok;
    int gap, dat, dn;
    exp_b[0] = w[15:8]; exp_b[1] = w[7:0]; exp_b[2] = 8'h0D; exp_b[3] = 8'h0A;
    for (int n = 0; n < 4; n++) begin
      if (n == 3) word = w_next;
      get_char(b, fok, gap, dat, dn);
      chk(fok, {"R2 frame ", tag}, int'(fok), 1);
      chk(b === exp_b[n], {"R3 byte ", tag}, int'(b), int'(exp_b[n]));
      if (n < 3) begin
        chk(gap == 2, {"R7 inner gap ", tag}, gap, 2);
        chk(dn == 0, {"R4 no strobe mid-record ", tag}, dn, 0);
      end else begin
        chk(gap == 3, {"R7 record gap ", tag}, gap, 3);
        chk(dn == 1 && dat == 1, {"R4 strobe count/pos ", tag}, dn * 16 + dat, 17);
      end
    end
  endtask

  task automatic t_reset_hold(input int cycles, input string tag);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(tx === 1'b1 && done === 1'b0, {"R1 reset idle ", tag}, {tx, done}, 2);
    end
    rst = 1'b0;
  endtask

  task automatic t_reset_mid();
    int cyc;
    for (int i = 0; i < 3 * C; i++) @(negedge clk);
    t_reset_hold(4, "mid");
    @(negedge clk);
    chk(tx === 1'b0, "R9 start on first edge after reset", int'(tx), 0);
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tx === 1'b1 && done === 1'b0, "R1 reset at power-up", {tx, done}, 2);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(tx === 1'b0, "R9 start on first edge after reset", int'(tx), 0);
    t_record(16'hAB7C, 16'hAB7C, "first");
    t_record(16'hAB7C, 16'h1234, "R5 repeat");
    t_record(16'h1234, 16'h1234, "R8 new word");
    t_reset_mid();
    t_record(16'h1234, 16'h00FF, "R9 after reset");
    t_record(16'h00FF, 16'h00FF, "R6 zeros-ones");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule